// File: doc/BRIEF.md
# Burst-Addressed Dual-Port Synchronous RAM

This block is a word-organised static memory with two fully independent ports, A and B. Each port has its own clock and reset. Each port captures its control, address and write data in registers on the rising edge of its clock. Both ports may reach any word in the same cycle, including the same word, and neither port ever stalls the other. Each word is two bytes wide by default, and every byte lane has its own active-low write enable.

Each port keeps its access address in a private burst pointer. The pointer can be cleared, loaded from the address pins, stepped by one, or held. A stream of consecutive words can therefore be read or written after a single address is supplied.

A live mode pin on each port chooses the read latency. In flow-through mode the word is presented in the cycle after the request is captured. In pipelined mode the word passes through one more register and appears a clock later. An output-enable pin gates only what is presented; the read itself still takes place. Each port is selected only when its low-active enable is low and its high-active enable is high. This lets several instances share a bus for depth expansion.

Top module: `burst_dpram`

## Requirements
- R1: A port acts only in cycles where `x_ce0_n`=0 and `x_ce1`=1 were captured. In any other enable combination it writes nothing, and the read it would have produced shows `x_rvalid`=0.
- R2: With `x_piped`=0, a read captured at a clock edge presents `x_rvalid`=1 and the addressed word on `x_rdata` after that same edge. A read `x_rd_wr`=1 issued in the cycle after a write to the same word returns the new word.
- R3: With `x_piped`=1, the read result appears one clock edge later than in R2. The cycle right after an idle cycle therefore shows `x_rvalid`=0.
- R4: A write (`x_rd_wr`=0) stores only the enabled bytes: `x_ben_n[1]`=0 enables bits 15:8 and `x_ben_n[0]`=0 enables bits 7:0, and a disabled lane keeps its old value. Reads always return the full word.
- R5: `x_clr_n`=0 at an edge sets the port's pointer to 0. This overrides load and step.
- R6: Otherwise, `x_load_n`=0 loads `x_addr` into the pointer, with priority over stepping. Otherwise, `x_step_n`=0 adds one, wrapping from the last word to word 0. Otherwise, the pointer holds. The pointer runs whether or not the port is selected.
- R7: While `x_oe_n`=1, `x_rvalid`=0 and `x_rdata`=0. A read issued with `x_oe_n`=1 still happens, and its pipelined result is shown once `x_oe_n` returns to 0.
- R8: Both ports may read the same word in one cycle. Writes from the two ports to different bytes of one word both take effect, and a word written by one port is read back by the other.
- R9: If a read on one port meets a write to the same word on the other port in one cycle, the read returns either the old or the new word. If both ports write the same byte of one word together, the stored byte is undefined.
- R10: While a port's `x_rst_n` is 0, `x_rvalid`=0 and `x_rdata`=0, and its pointer is 0. After reset, a first read with no load or step returns word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A asynchronous reset, active low |
| a_ce0_n | input | 1 | Port A enable, active low |
| a_ce1 | input | 1 | Port A enable, active high |
| a_rd_wr | input | 1 | Port A direction: 1 read, 0 write |
| a_ben_n | input | DW/8 | Port A byte-lane write enables, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_piped | input | 1 | Port A latency: 0 flow-through, 1 pipelined |
| a_load_n | input | 1 | Port A pointer load from a_addr, active low |
| a_step_n | input | 1 | Port A pointer step, active low |
| a_clr_n | input | 1 | Port A pointer clear, active low |
| a_addr | input | AW | Port A address to load |
| a_wdata | input | DW | Port A write word |
| a_rdata | output | DW | Port A read word, 0 when not valid |
| a_rvalid | output | 1 | Port A read word valid |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B asynchronous reset, active low |
| b_ce0_n | input | 1 | Port B enable, active low |
| b_ce1 | input | 1 | Port B enable, active high |
| b_rd_wr | input | 1 | Port B direction: 1 read, 0 write |
| b_ben_n | input | DW/8 | Port B byte-lane write enables, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_piped | input | 1 | Port B latency: 0 flow-through, 1 pipelined |
| b_load_n | input | 1 | Port B pointer load from b_addr, active low |
| b_step_n | input | 1 | Port B pointer step, active low |
| b_clr_n | input | 1 | Port B pointer clear, active low |
| b_addr | input | AW | Port B address to load |
| b_wdata | input | DW | Port B write word |
| b_rdata | output | DW | Port B read word, 0 when not valid |
| b_rvalid | output | 1 | Port B read word valid |

## Verification
The cases where two functions fall in the same cycle are provoked on purpose.

In the first case, the two ports hit one word together. Both ports read the same word in one cycle. Both ports write complementary byte lanes of one word in one cycle, and the merged word is then checked. One port writes a word while the other reads it, and the read is accepted as either the old or the new word.

In the second case, the pointer controls are asserted together. Clear, load and step are raised in one cycle, and then load and step alone. The word read back shows which control won.

A third case tests the output enable. A pipelined read is issued with the output enable off, and the output enable is turned back on in the next cycle. This shows that the read took place behind the gate.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

   typedef enum logic [1:0] {
      CTR_HOLD  = 2'd0,
      CTR_STEP  = 2'd1,
      CTR_LOAD  = 2'd2,
      CTR_CLEAR = 2'd3
   } ctr_op_e;

   typedef struct packed {
      logic rd;
      logic wr;
   } acc_s;

   // clear beats load, load beats step
   function automatic ctr_op_e ctr_decode(input logic clr_n, input logic load_n,
                                          input logic step_n);
      ctr_op_e op;
      if (!clr_n)       op = CTR_CLEAR;
      else if (!load_n) op = CTR_LOAD;
      else if (!step_n) op = CTR_STEP;
      else              op = CTR_HOLD;
      return op;
   endfunction

endpackage

// File: rtl/bdp_ctr.sv
module bdp_ctr
   import bdp_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  ctr_op_e       op,
   input  logic [AW-1:0] load_addr,
   output logic [AW-1:0] ptr
);

   if (AW < 1) begin : g_bad_aw
      $error("bdp_ctr: AW must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else begin
         unique case (op)
            CTR_CLEAR: ptr <= '0;
            CTR_LOAD:  ptr <= load_addr;
            CTR_STEP:  ptr <= ptr + AW'(1);   // natural wrap at 2**AW
            default:   ptr <= ptr;
         endcase
      end
   end

endmodule

// File: rtl/bdp_bank.sv
module bdp_bank #(
   parameter int AW = 4,
   parameter int DW = 16,
   parameter int NB = DW / 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [NB-1:0] lane_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] peer_addr,
   output logic [DW-1:0] own_rd,
   output logic [DW-1:0] peer_rd
);

   localparam int DEPTH = 1 << AW;

   if (NB * 8 != DW) begin : g_bad_nb
      $error("bdp_bank: NB*8 must equal DW");
   end

   logic [DW-1:0] store [DEPTH];
   logic [DW-1:0] merged;

   assign own_rd  = store[addr];
   assign peer_rd = store[peer_addr];

   for (genvar g = 0; g < NB; g++) begin : g_lane
      assign merged[g*8 +: 8] = lane_en[g] ? wdata[g*8 +: 8] : own_rd[g*8 +: 8];
   end

   always_ff @(posedge clk) begin
      if (we) store[addr] <= merged;
   end

endmodule

// File: rtl/bdp_port.sv
module bdp_port
   import bdp_pkg::*;
#(
   parameter int AW = 4,
   parameter int DW = 16,
   parameter int NB = DW / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce0_n,
   input  logic          ce1,
   input  logic          rd_wr,
   input  logic [NB-1:0] ben_n,
   input  logic          oe_n,
   input  logic          piped,
   input  logic          load_n,
   input  logic          step_n,
   input  logic          clr_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] peer_addr,
   input  logic [DW-1:0] peer_word,
   output logic [DW-1:0] peer_rd,
   output logic [AW-1:0] ptr,
   output logic [DW-1:0] rdata,
   output logic          rvalid
);

   logic          selected;
   acc_s          req_q;
   logic [NB-1:0] lane_q;
   logic [DW-1:0] wdat_q;
   ctr_op_e       op;
   logic [DW-1:0] own_rd;
   logic [DW-1:0] word;
   logic [DW-1:0] enc_wdata;
   logic          pp_vld;
   logic [DW-1:0] pp_dat;
   logic          stage_vld;
   logic [DW-1:0] stage_dat;

   assign selected = ~ce0_n & ce1;
   assign op       = ctr_decode(clr_n, load_n, step_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= '0;
         lane_q <= '0;
         wdat_q <= '0;
      end else begin
         req_q.rd <= selected & rd_wr;
         req_q.wr <= selected & ~rd_wr;
         lane_q   <= ~ben_n;
         wdat_q   <= wdata;
      end
   end

   bdp_ctr #(.AW(AW)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .load_addr (addr),
      .ptr       (ptr)
   );

   // this bank holds word ^ peer bank, so the stored word is own ^ peer
   assign word      = own_rd ^ peer_word;
   assign enc_wdata = wdat_q ^ peer_word;

   bdp_bank #(.AW(AW), .DW(DW), .NB(NB)) u_bank (
      .clk       (clk),
      .we        (req_q.wr),
      .lane_en   (lane_q),
      .addr      (ptr),
      .wdata     (enc_wdata),
      .peer_addr (peer_addr),
      .own_rd    (own_rd),
      .peer_rd   (peer_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pp_vld <= 1'b0;
         pp_dat <= '0;
      end else begin
         pp_vld <= req_q.rd;
         pp_dat <= word;
      end
   end

   assign stage_vld = piped ? pp_vld : req_q.rd;
   assign stage_dat = piped ? pp_dat : word;
   assign rvalid    = stage_vld & ~oe_n;
   assign rdata     = rvalid ? stage_dat : '0;

endmodule

// File: rtl/burst_dpram.sv
module burst_dpram #(
   parameter int AW = 4,
   parameter int DW = 16
) (
   input  logic            a_clk,
   input  logic            a_rst_n,
   input  logic            a_ce0_n,
   input  logic            a_ce1,
   input  logic            a_rd_wr,
   input  logic [DW/8-1:0] a_ben_n,
   input  logic            a_oe_n,
   input  logic            a_piped,
   input  logic            a_load_n,
   input  logic            a_step_n,
   input  logic            a_clr_n,
   input  logic [AW-1:0]   a_addr,
   input  logic [DW-1:0]   a_wdata,
   output logic [DW-1:0]   a_rdata,
   output logic            a_rvalid,
   input  logic            b_clk,
   input  logic            b_rst_n,
   input  logic            b_ce0_n,
   input  logic            b_ce1,
   input  logic            b_rd_wr,
   input  logic [DW/8-1:0] b_ben_n,
   input  logic            b_oe_n,
   input  logic            b_piped,
   input  logic            b_load_n,
   input  logic            b_step_n,
   input  logic            b_clr_n,
   input  logic [AW-1:0]   b_addr,
   input  logic [DW-1:0]   b_wdata,
   output logic [DW-1:0]   b_rdata,
   output logic            b_rvalid
);

   localparam int NB = DW / 8;

   if (DW < 8 || DW % 8 != 0) begin : g_bad_dw
      $error("burst_dpram: DW must be a non-zero multiple of 8");
   end
   if (AW < 1 || AW > 16) begin : g_bad_aw
      $error("burst_dpram: AW must lie in 1..16");
   end

   logic [AW-1:0] a_ptr;
   logic [AW-1:0] b_ptr;
   logic [DW-1:0] a_to_b;
   logic [DW-1:0] b_to_a;

   bdp_port #(.AW(AW), .DW(DW), .NB(NB)) u_port_a (
      .clk       (a_clk),
      .rst_n     (a_rst_n),
      .ce0_n     (a_ce0_n),
      .ce1       (a_ce1),
      .rd_wr     (a_rd_wr),
      .ben_n     (a_ben_n),
      .oe_n      (a_oe_n),
      .piped     (a_piped),
      .load_n    (a_load_n),
      .step_n    (a_step_n),
      .clr_n     (a_clr_n),
      .addr      (a_addr),
      .wdata     (a_wdata),
      .peer_addr (b_ptr),
      .peer_word (b_to_a),
      .peer_rd   (a_to_b),
      .ptr       (a_ptr),
      .rdata     (a_rdata),
      .rvalid    (a_rvalid)
   );

   bdp_port #(.AW(AW), .DW(DW), .NB(NB)) u_port_b (
      .clk       (b_clk),
      .rst_n     (b_rst_n),
      .ce0_n     (b_ce0_n),
      .ce1       (b_ce1),
      .rd_wr     (b_rd_wr),
      .ben_n     (b_ben_n),
      .oe_n      (b_oe_n),
      .piped     (b_piped),
      .load_n    (b_load_n),
      .step_n    (b_step_n),
      .clr_n     (b_clr_n),
      .addr      (b_addr),
      .wdata     (b_wdata),
      .peer_addr (a_ptr),
      .peer_word (a_to_b),
      .peer_rd   (b_to_a),
      .ptr       (b_ptr),
      .rdata     (b_rdata),
      .rvalid    (b_rvalid)
   );

endmodule

// File: rtl/bdp_check.sv
module bdp_check #(
   parameter int AW = 4,
   parameter int DW = 16
) (
   input logic          a_clk,
   input logic          a_rst_n,
   input logic          a_ce0_n,
   input logic          a_ce1,
   input logic          a_rd_wr,
   input logic          a_oe_n,
   input logic          a_piped,
   input logic          a_load_n,
   input logic          a_step_n,
   input logic          a_clr_n,
   input logic [AW-1:0] a_addr,
   input logic [AW-1:0] a_ptr,
   input logic [DW-1:0] a_rdata,
   input logic          a_rvalid,
   input logic          b_clk,
   input logic          b_rst_n,
   input logic          b_oe_n,
   input logic          b_load_n,
   input logic          b_clr_n,
   input logic [AW-1:0] b_addr,
   input logic [AW-1:0] b_ptr,
   input logic [DW-1:0] b_rdata,
   input logic          b_rvalid
);

   logic [1:0] a_age;
   logic [1:0] b_age;

   always_ff @(posedge a_clk or negedge a_rst_n) begin
      if (!a_rst_n)          a_age <= '0;
      else if (a_age != 2'd3) a_age <= a_age + 2'd1;
   end

   always_ff @(posedge b_clk or negedge b_rst_n) begin
      if (!b_rst_n)          b_age <= '0;
      else if (b_age != 2'd3) b_age <= b_age + 2'd1;
   end

   a_r5_clear_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
      (a_age != 2'd0 && !$past(a_clr_n)) |-> a_ptr == '0);

   a_r6_load_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
      (a_age != 2'd0 && $past(a_clr_n) && !$past(a_load_n)) |-> a_ptr == $past(a_addr));

   a_r6_step_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
      (a_age != 2'd0 && $past(a_clr_n) && $past(a_load_n) && !$past(a_step_n))
      |-> a_ptr == $past(a_ptr) + AW'(1));

   a_r6_hold_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
      (a_age != 2'd0 && $past(a_clr_n) && $past(a_load_n) && $past(a_step_n))
      |-> $stable(a_ptr));

   // R1 selection folds into both latency checks below
   a_r2_flow_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
      (a_age >= 2'd2 && !a_piped && !a_oe_n)
      |-> a_rvalid == $past(!a_ce0_n && a_ce1 && a_rd_wr));

   a_r3_pipe_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
      (a_age >= 2'd2 && a_piped && !a_oe_n)
      |-> a_rvalid == $past(!a_ce0_n && a_ce1 && a_rd_wr, 2));

   a_r7_oe_gate_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
      a_oe_n |-> (!a_rvalid && a_rdata == '0));

   a_r5_clear_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      (b_age != 2'd0 && !$past(b_clr_n)) |-> b_ptr == '0);

   a_r6_load_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      (b_age != 2'd0 && $past(b_clr_n) && !$past(b_load_n)) |-> b_ptr == $past(b_addr));

   a_r7_oe_gate_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      b_oe_n |-> (!b_rvalid && b_rdata == '0));

endmodule

bind burst_dpram bdp_check #(.AW(AW), .DW(DW)) u_check (
   .a_clk    (a_clk),
   .a_rst_n  (a_rst_n),
   .a_ce0_n  (a_ce0_n),
   .a_ce1    (a_ce1),
   .a_rd_wr  (a_rd_wr),
   .a_oe_n   (a_oe_n),
   .a_piped  (a_piped),
   .a_load_n (a_load_n),
   .a_step_n (a_step_n),
   .a_clr_n  (a_clr_n),
   .a_addr   (a_addr),
   .a_ptr    (a_ptr),
   .a_rdata  (a_rdata),
   .a_rvalid (a_rvalid),
   .b_clk    (b_clk),
   .b_rst_n  (b_rst_n),
   .b_oe_n   (b_oe_n),
   .b_load_n (b_load_n),
   .b_clr_n  (b_clr_n),
   .b_addr   (b_addr),
   .b_ptr    (b_ptr),
   .b_rdata  (b_rdata),
   .b_rvalid (b_rvalid)
);

// File: tb/burst_dpram_tb.sv
module burst_dpram_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 4;
   localparam int DW = 16;
   localparam int NB = DW / 8;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic          a_rst_n, a_ce0_n, a_ce1, a_rd_wr, a_oe_n, a_piped;
   logic          a_load_n, a_step_n, a_clr_n;
   logic [NB-1:0] a_ben_n;
   logic [AW-1:0] a_addr;
   logic [DW-1:0] a_wdata, a_rdata;
   logic          a_rvalid;
   logic          b_rst_n, b_ce0_n, b_ce1, b_rd_wr, b_oe_n, b_piped;
   logic          b_load_n, b_step_n, b_clr_n;
   logic [NB-1:0] b_ben_n;
   logic [AW-1:0] b_addr;
   logic [DW-1:0] b_wdata, b_rdata;
   logic          b_rvalid;

   burst_dpram #(.AW(AW), .DW(DW)) u_dut (
      .a_clk(clk), .a_rst_n(a_rst_n), .a_ce0_n(a_ce0_n), .a_ce1(a_ce1),
      .a_rd_wr(a_rd_wr), .a_ben_n(a_ben_n), .a_oe_n(a_oe_n), .a_piped(a_piped),
      .a_load_n(a_load_n), .a_step_n(a_step_n), .a_clr_n(a_clr_n),
      .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
      .b_clk(clk), .b_rst_n(b_rst_n), .b_ce0_n(b_ce0_n), .b_ce1(b_ce1),
      .b_rd_wr(b_rd_wr), .b_ben_n(b_ben_n), .b_oe_n(b_oe_n), .b_piped(b_piped),
      .b_load_n(b_load_n), .b_step_n(b_step_n), .b_clr_n(b_clr_n),
      .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_rvalid(b_rvalid)
   );

   int n_cmp = 0;
   int n_bad = 0;
   logic done = 1'b0;
   logic [DW-1:0] model [DEPTH];

   function automatic logic [DW-1:0] pat(input int i);
      return DW'(i * 16'h1F3B + 16'h0C5A);
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drv_a(input logic sel, input logic rd, input logic [NB-1:0] ben_n,
                        input logic [AW-1:0] ad, input logic [DW-1:0] wd,
                        input logic ld_n, input logic st_n, input logic cl_n);
      a_ce0_n = ~sel; a_ce1 = sel; a_rd_wr = rd; a_ben_n = ben_n; a_addr = ad;
      a_wdata = wd; a_load_n = ld_n; a_step_n = st_n; a_clr_n = cl_n;
   endtask

   task automatic drv_b(input logic sel, input logic rd, input logic [NB-1:0] ben_n,
                        input logic [AW-1:0] ad, input logic [DW-1:0] wd,
                        input logic ld_n, input logic st_n, input logic cl_n);
      b_ce0_n = ~sel; b_ce1 = sel; b_rd_wr = rd; b_ben_n = ben_n; b_addr = ad;
      b_wdata = wd; b_load_n = ld_n; b_step_n = st_n; b_clr_n = cl_n;
   endtask

   task automatic idle_a(); drv_a(1'b0, 1'b1, '1, '0, '0, 1'b1, 1'b1, 1'b1); endtask
   task automatic idle_b(); drv_b(1'b0, 1'b1, '1, '0, '0, 1'b1, 1'b1, 1'b1); endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog got=running exp=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] tmp, old_w, new_w;
      a_rst_n = 1'b0; b_rst_n = 1'b0;
      a_oe_n = 1'b0; b_oe_n = 1'b0; a_piped = 1'b0; b_piped = 1'b0;
      idle_a(); idle_b();
      repeat (3) tick();
      chk("R10 a_rvalid in reset", a_rvalid, 0);
      chk("R10 a_rdata in reset", a_rdata, 0);
      chk("R10 b_rvalid in reset", b_rvalid, 0);
      chk("R10 b_rdata in reset", b_rdata, 0);
      a_rst_n = 1'b1; b_rst_n = 1'b1;
      tick();

      // fill every word from A with a load then steps
      for (int i = 0; i < DEPTH; i++) begin
         drv_a(1'b1, 1'b0, '0, '0, pat(i), (i == 0) ? 1'b0 : 1'b1,
               (i == 0) ? 1'b1 : 1'b0, 1'b1);
         model[i] = pat(i);
         tick();
      end
      idle_a();
      tick();

      // R10 / R6 / R2: B pointer still 0, read word 0 with hold, then step and wrap
      for (int i = 0; i <= DEPTH; i++) begin
         drv_b(1'b1, 1'b1, '1, '0, '0, 1'b1, (i == 0) ? 1'b1 : 1'b0, 1'b1);
         tick();
         chk("R2 flow valid B", b_rvalid, 1);
         chk((i == 0) ? "R10 first read word 0" : "R6 burst step/wrap B",
             b_rdata, model[i % DEPTH]);
      end
      idle_b();
      tick();
      chk("R1 deselected B not valid", b_rvalid, 0);

      // R4 byte-masked writes from B, lane mask i%4 (bit1 upper, bit0 lower)
      for (int i = 0; i < DEPTH; i++) begin
         logic [NB-1:0] m;
         m   = NB'(i % 4);
         tmp = ~pat(i) ^ 16'h0F0F;
         drv_b(1'b1, 1'b0, ~m, AW'(i), tmp, 1'b0, 1'b1, 1'b1);
         for (int l = 0; l < NB; l++)
            if (m[l]) model[i][l*8 +: 8] = tmp[l*8 +: 8];
         tick();
      end
      idle_b();
      tick();

      // R3 pipelined burst read on A; R4 data checked here
      a_piped = 1'b1;
      tick();
      for (int i = 0; i < DEPTH; i++) begin
         drv_a(1'b1, 1'b1, '1, '0, '0, (i == 0) ? 1'b0 : 1'b1,
               (i == 0) ? 1'b1 : 1'b0, 1'b1);
         tick();
         if (i == 0) begin
            chk("R3 no data one edge after idle", a_rvalid, 0);
         end else begin
            chk("R3 pipe valid", a_rvalid, 1);
            chk("R4 masked word via pipe", a_rdata, model[i-1]);
         end
      end
      idle_a();
      tick();
      chk("R4 masked last word", a_rdata, model[DEPTH-1]);
      tick();
      chk("R3 drains after two edges", a_rvalid, 0);

      // R5 / R6: pointer priorities on A, flow-through
      a_piped = 1'b0;
      drv_a(1'b1, 1'b1, '1, 4'd5, '0, 1'b0, 1'b1, 1'b1); tick();
      chk("R6 load 5", a_rdata, model[5]);
      drv_a(1'b1, 1'b1, '1, 4'd0, '0, 1'b1, 1'b0, 1'b1); tick();
      chk("R6 step to 6", a_rdata, model[6]);
      tick();
      chk("R6 step to 7", a_rdata, model[7]);
      drv_a(1'b1, 1'b1, '1, 4'd9, '0, 1'b0, 1'b0, 1'b0); tick();
      chk("R5 clear beats load and step", a_rdata, model[0]);
      drv_a(1'b1, 1'b1, '1, 4'd0, '0, 1'b1, 1'b0, 1'b1); tick();
      chk("R5 step after clear", a_rdata, model[1]);
      drv_a(1'b1, 1'b1, '1, 4'd9, '0, 1'b0, 1'b0, 1'b1); tick();
      chk("R6 load beats step", a_rdata, model[9]);
      drv_a(1'b1, 1'b1, '1, 4'd2, '0, 1'b1, 1'b1, 1'b1); tick();
      chk("R6 hold", a_rdata, model[9]);

      // R1: every deselecting enable pair blocks writes and reads
      for (int c = 0; c < 3; c++) begin
         drv_a(1'b1, 1'b0, '0, 4'd3, 16'hDEAD, 1'b0, 1'b1, 1'b1);
         a_ce0_n = (c != 1);
         a_ce1   = (c == 0);
         tick();
         a_rd_wr = 1'b1;
         tick();
         chk("R1 deselected read not valid", a_rvalid, 0);
      end
      drv_a(1'b1, 1'b1, '1, 4'd3, '0, 1'b0, 1'b1, 1'b1); tick();
      chk("R1 deselected write ignored", a_rdata, model[3]);

      // R7: output enable gates only the output
      a_oe_n = 1'b1;
      drv_a(1'b1, 1'b1, '1, 4'd4, '0, 1'b0, 1'b1, 1'b1); tick();
      chk("R7 oe off hides valid", a_rvalid, 0);
      chk("R7 oe off zero data", a_rdata, 0);
      a_piped = 1'b1;
      drv_a(1'b1, 1'b1, '1, 4'd6, '0, 1'b0, 1'b1, 1'b1); tick();
      idle_a();
      a_oe_n = 1'b0;
      tick();
      chk("R7 read behind oe was done", a_rvalid, 1);
      chk("R7 read behind oe data", a_rdata, model[6]);
      a_piped = 1'b0;
      tick();

      // R8: both ports read one word together
      drv_a(1'b1, 1'b1, '1, 4'd7, '0, 1'b0, 1'b1, 1'b1);
      drv_b(1'b1, 1'b1, '1, 4'd7, '0, 1'b0, 1'b1, 1'b1);
      tick();
      chk("R8 same word A", a_rdata, model[7]);
      chk("R8 same word B", b_rdata, model[7]);

      // R8: complementary lanes of word 8 in one cycle
      drv_a(1'b1, 1'b0, 2'b01, 4'd8, 16'hAB12, 1'b0, 1'b1, 1'b1);
      drv_b(1'b1, 1'b0, 2'b10, 4'd8, 16'h34CD, 1'b0, 1'b1, 1'b1);
      model[8] = 16'hABCD;
      tick();
      idle_a(); idle_b();
      tick();
      drv_a(1'b1, 1'b1, '1, 4'd8, '0, 1'b0, 1'b1, 1'b1);
      drv_b(1'b1, 1'b1, '1, 4'd8, '0, 1'b0, 1'b1, 1'b1);
      tick();
      chk("R8 merged lanes via A", a_rdata, model[8]);
      chk("R8 merged lanes via B", b_rdata, model[8]);

      // R9: A writes word 11 while B reads it; then R8 cross visibility
      old_w = model[11];
      new_w = 16'h5EED;
      drv_a(1'b1, 1'b0, '0, 4'd11, new_w, 1'b0, 1'b1, 1'b1);
      drv_b(1'b1, 1'b1, '1, 4'd11, '0, 1'b0, 1'b1, 1'b1);
      model[11] = new_w;
      tick();
      n_cmp++;
      if (b_rdata !== old_w && b_rdata !== new_w) begin
         n_bad++;
         $display("FAIL R9 collision read got=%h exp=%h or %h", b_rdata, old_w, new_w);
      end
      idle_a();
      tick();
      chk("R8 write by A read by B", b_rdata, model[11]);

      // R2 / R3 run-time switch on B: same word, both latencies
      drv_b(1'b1, 1'b1, '1, 4'd12, '0, 1'b0, 1'b1, 1'b1); tick();
      chk("R2 flow word 12", b_rdata, model[12]);
      b_piped = 1'b1;
      idle_b(); tick();
      chk("R3 pipe after switch", b_rdata, model[12]);
      tick();
      chk("R3 pipe empty", b_rvalid, 0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule